// File: doc/BRIEF.md
# Transparent Address Window Matcher

This block decides, for every bus access, whether the access bypasses table-based address translation. It holds a small set of programmable windows (two by default). Each window describes a region of the logical address space by the upper address bits, the access function code and, optionally, the access direction. An access that falls inside any enabled window is translated transparently: the physical address equals the logical address, and the block raises a hit flag. An access that falls inside no window leaves the hit flag low, which tells the surrounding logic that the translation tables must be used instead.

Each window also carries a cache-inhibit bit. When a window with that bit set matches an access, the block raises a cache-inhibit output for the caches that consume it. When several windows match, their cache-inhibit bits are ORed. The windows are loaded through a simple write port that writes every field of one selected window in a single clock. The match outputs are purely combinational from the access inputs and the stored window state.

Top module: `xlat_window_match`

## Requirements
- R1: After reset every window is disabled, so `xw_hit`, `xw_cinh` and `xw_paddr` are all 0 for any access until a window is written.
- R2: A window compares its 8-bit tag with the top 8 bits of `acc_addr`; a 1 in the tag mask makes that bit a don't-care (tag 0x00 with mask 0x0F covers 0x00000000 to 0x0FFFFFFF and nothing from 0x10000000 upward).
- R3: When a window's direction-ignore bit is 1, the access direction has no effect on its match; when it is 0, `acc_rd` (1 = read, 0 = write) must equal the window's direction bit.
- R4: A window compares its 3-bit code base with `acc_fc`; a 1 in the code mask makes that bit a don't-care, and a mask of 0 demands an exact code.
- R5: `xw_hit` is 1 when at least one enabled window matches on tag, code and direction; a window whose enable bit is 0 never matches.
- R6: `xw_cinh` is the OR of the cache-inhibit bits of all matching windows and is 0 whenever no window matches.
- R7: With `xw_hit` 1, `xw_paddr` equals `acc_addr`; with `xw_hit` 0 and the default `MISS_PASS` of 0, `xw_paddr` is 0.
- R8: `xw_hit`, `xw_cinh` and `xw_paddr` follow the access inputs in the same cycle, with no register in the path.
- R9: When `wr_en` is 1 at a rising clock edge, all fields of window `wr_sel` (0 or 1) are replaced by the `wr_*` inputs; an access presented in the cycle of the write is judged with the configuration held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the window registers |
| rst_n | input | 1 | Asynchronous active-low reset, disables all windows |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_sel | input | 1 | Index of the window being written |
| wr_on | input | 1 | Enable bit for the written window |
| wr_tag | input | 8 | Logical tag compared with the top address bits |
| wr_tag_msk | input | 8 | Tag don't-care mask |
| wr_dir | input | 1 | Required direction, 1 = read |
| wr_dir_any | input | 1 | 1 = direction ignored |
| wr_fc | input | 3 | Function-code base |
| wr_fc_msk | input | 3 | Function-code don't-care mask |
| wr_ci | input | 1 | Cache-inhibit bit of the written window |
| acc_addr | input | 32 | Logical address of the access |
| acc_fc | input | 3 | Function code of the access |
| acc_rd | input | 1 | Access direction, 1 = read |
| xw_hit | output | 1 | Transparent translation hit |
| xw_cinh | output | 1 | Cache-inhibit for the access |
| xw_paddr | output | 32 | Physical address |

## Verification
The three match outputs are due in the same cycle as the access inputs, so the bench drives each access on the falling edge and samples one time unit later, well before the next rising edge, with no clock counted in between. Window writes are due one edge later: the bench drives the write on a falling edge, samples once before the following rising edge to confirm the old configuration still governs the access, and samples again after the next falling edge to see the new one. The reset check samples after reset release with no write performed.

// File: rtl/xwm_pkg.sv
package xwm_pkg;
   localparam int TAG_W = 8;
   localparam int FC_W  = 3;

   typedef struct packed {
      logic            on;
      logic [TAG_W-1:0] tag;
      logic [TAG_W-1:0] tag_msk;
      logic            dir;
      logic            dir_any;
      logic [FC_W-1:0] fc;
      logic [FC_W-1:0] fc_msk;
      logic            ci;
   } win_cfg_t;

   localparam win_cfg_t WIN_OFF = '0;
endpackage

// File: rtl/xwm_cfg_regs.sv
module xwm_cfg_regs
   import xwm_pkg::*;
#(
   parameter int NUM_WIN = 2,
   localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  win_cfg_t         wr_cfg,
   output win_cfg_t         cfg_q [NUM_WIN]
);
   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[w] <= WIN_OFF;
         end else if (wr_en && (wr_sel == SEL_W'(w))) begin
            cfg_q[w] <= wr_cfg;
         end
      end
   end
endmodule

// File: rtl/xwm_window_cmp.sv
module xwm_window_cmp
   import xwm_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  win_cfg_t          cfg,
   input  logic [ADDR_W-1:0] addr,
   input  logic [FC_W-1:0]   fc,
   input  logic              rd,
   output logic              match,
   output logic              ci_req
);
   logic [TAG_W-1:0] addr_tag;
   logic             tag_ok;
   logic             fc_ok;
   logic             dir_ok;

   always_comb begin
      addr_tag = addr[ADDR_W-1 -: TAG_W];
      tag_ok   = ((addr_tag ^ cfg.tag) & ~cfg.tag_msk) == '0;
      fc_ok    = ((fc ^ cfg.fc) & ~cfg.fc_msk) == '0;
      dir_ok   = cfg.dir_any || (rd == cfg.dir);
      match    = cfg.on && tag_ok && fc_ok && dir_ok;
      ci_req   = match && cfg.ci;
   end
endmodule

// File: rtl/xlat_window_match.sv
module xlat_window_match
   import xwm_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int NUM_WIN   = 2,
   parameter bit MISS_PASS = 1'b0,
   localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic              wr_on,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [TAG_W-1:0]  wr_tag_msk,
   input  logic              wr_dir,
   input  logic              wr_dir_any,
   input  logic [FC_W-1:0]   wr_fc,
   input  logic [FC_W-1:0]   wr_fc_msk,
   input  logic              wr_ci,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [FC_W-1:0]   acc_fc,
   input  logic              acc_rd,
   output logic              xw_hit,
   output logic              xw_cinh,
   output logic [ADDR_W-1:0] xw_paddr
);
   if (ADDR_W < TAG_W) begin : g_bad_addr_w
      $error("xlat_window_match: ADDR_W must be at least TAG_W");
   end
   if (NUM_WIN < 1) begin : g_bad_num_win
      $error("xlat_window_match: NUM_WIN must be at least 1");
   end

   win_cfg_t           wr_cfg;
   win_cfg_t           cfg_q [NUM_WIN];
   logic [NUM_WIN-1:0] win_match;
   logic [NUM_WIN-1:0] win_ci;

   always_comb begin
      wr_cfg.on      = wr_on;
      wr_cfg.tag     = wr_tag;
      wr_cfg.tag_msk = wr_tag_msk;
      wr_cfg.dir     = wr_dir;
      wr_cfg.dir_any = wr_dir_any;
      wr_cfg.fc      = wr_fc;
      wr_cfg.fc_msk  = wr_fc_msk;
      wr_cfg.ci      = wr_ci;
   end

   xwm_cfg_regs #(.NUM_WIN(NUM_WIN)) regs_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .wr_cfg (wr_cfg),
      .cfg_q  (cfg_q)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
      xwm_window_cmp #(.ADDR_W(ADDR_W)) cmp_i (
         .cfg    (cfg_q[w]),
         .addr   (acc_addr),
         .fc     (acc_fc),
         .rd     (acc_rd),
         .match  (win_match[w]),
         .ci_req (win_ci[w])
      );
   end

   assign xw_hit  = |win_match;
   assign xw_cinh = |win_ci;

   if (MISS_PASS) begin : g_miss_pass
      assign xw_paddr = acc_addr;
   end else begin : g_miss_zero
      assign xw_paddr = xw_hit ? acc_addr : '0;
   end
endmodule

// File: rtl/xwm_checker.sv
module xwm_checker #(
   parameter int ADDR_W = 32,
   parameter bit MISS_PASS = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [2:0]        acc_fc,
   input logic              acc_rd,
   input logic              xw_hit,
   input logic              xw_cinh,
   input logic [ADDR_W-1:0] xw_paddr
);
   AST_RESET_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !xw_hit && !xw_cinh); // R1

   AST_CINH_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      xw_cinh |-> xw_hit); // R6

   AST_HIT_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
      xw_hit |-> xw_paddr == acc_addr); // R7

   AST_MISS_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (!xw_hit && !MISS_PASS) |-> xw_paddr == '0); // R7

   AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(wr_en) && $stable(acc_addr) && $stable(acc_fc) && $stable(acc_rd))
      |-> $stable(xw_hit) && $stable(xw_cinh)); // R9
endmodule

bind xlat_window_match xwm_checker #(.ADDR_W(ADDR_W), .MISS_PASS(MISS_PASS)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .acc_addr (acc_addr),
   .acc_fc   (acc_fc),
   .acc_rd   (acc_rd),
   .xw_hit   (xw_hit),
   .xw_cinh  (xw_cinh),
   .xw_paddr (xw_paddr)
);

// File: tb/xlat_window_match_tb_top.sv
module xlat_window_match_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [0:0]  wr_sel = '0;
   logic        wr_on = 1'b0, wr_dir = 1'b0, wr_dir_any = 1'b0, wr_ci = 1'b0;
   logic [7:0]  wr_tag = '0, wr_tag_msk = '0;
   logic [2:0]  wr_fc = '0, wr_fc_msk = '0;
   logic [31:0] acc_addr = '0;
   logic [2:0]  acc_fc = '0;
   logic        acc_rd = 1'b0;
   logic        xw_hit, xw_cinh;
   logic [31:0] xw_paddr;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xlat_window_match dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_on(wr_on),
      .wr_tag(wr_tag), .wr_tag_msk(wr_tag_msk), .wr_dir(wr_dir), .wr_dir_any(wr_dir_any),
      .wr_fc(wr_fc), .wr_fc_msk(wr_fc_msk), .wr_ci(wr_ci),
      .acc_addr(acc_addr), .acc_fc(acc_fc), .acc_rd(acc_rd),
      .xw_hit(xw_hit), .xw_cinh(xw_cinh), .xw_paddr(xw_paddr)
   );

   // {addr, fc, rd, exp_hit, exp_cinh} with window 0: tag 00/msk 0F, read only, fc 5, ci
   // and window 1: any tag, any direction, fc 2, no ci
   localparam logic [37:0] VEC [NVEC] = '{
      {32'h0123_4567, 3'd5, 1'b1, 1'b1, 1'b1},
      {32'h0FFF_FFFF, 3'd5, 1'b1, 1'b1, 1'b1},
      {32'h1000_0000, 3'd5, 1'b1, 1'b0, 1'b0},
      {32'h0123_4567, 3'd5, 1'b0, 1'b0, 1'b0},
      {32'h8000_0000, 3'd2, 1'b0, 1'b1, 1'b0},
      {32'h8000_0000, 3'd2, 1'b1, 1'b1, 1'b0},
      {32'h0000_0010, 3'd3, 1'b1, 1'b0, 1'b0},
      {32'h0000_0000, 3'd4, 1'b1, 1'b0, 1'b0}
   };

   task automatic check(input string req, input logic hit_e, input logic ci_e);
      logic [31:0] pa_e;
      pa_e = hit_e ? acc_addr : 32'h0;
      n_run++;
      if (xw_hit !== hit_e || xw_cinh !== ci_e || xw_paddr !== pa_e) begin
         n_fail++;
         $display("FAIL %s addr=%h fc=%0d rd=%0b: got hit=%0b ci=%0b pa=%h, want hit=%0b ci=%0b pa=%h",
                  req, acc_addr, acc_fc, acc_rd, xw_hit, xw_cinh, xw_paddr, hit_e, ci_e, pa_e);
      end
   endtask

   task automatic access(input logic [31:0] a, input logic [2:0] f, input logic r);
      @(negedge clk);
      acc_addr = a; acc_fc = f; acc_rd = r;
      #1;
   endtask

   task automatic write_win(input logic s, input logic on, input logic [7:0] t, input logic [7:0] tm,
                            input logic d, input logic da, input logic [2:0] f, input logic [2:0] fm,
                            input logic c);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_on = on; wr_tag = t; wr_tag_msk = tm;
      wr_dir = d; wr_dir_any = da; wr_fc = f; wr_fc_msk = fm; wr_ci = c;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: nothing matches after reset, even an access a full-open window would take
      access(32'h0000_0000, 3'd0, 1'b1);  check("R1", 1'b0, 1'b0);
      access(32'hFFFF_FFFF, 3'd7, 1'b0);  check("R1", 1'b0, 1'b0);

      write_win(1'b0, 1'b1, 8'h00, 8'h0F, 1'b1, 1'b0, 3'd5, 3'd0, 1'b1);
      write_win(1'b1, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b1, 3'd2, 3'd0, 1'b0);
      // R2 R3 R4 R5 R6 R7 R8: table walk
      for (int i = 0; i < NVEC; i++) begin
         access(VEC[i][37:6], VEC[i][5:3], VEC[i][2]);
         check("R2/R3/R4/R5/R6/R7/R8 table", VEC[i][1], VEC[i][0]);
      end

      // R6: both windows match, ci ORed (window 1 reprogrammed to fc 5, no ci)
      write_win(1'b1, 1'b1, 8'h00, 8'h0F, 1'b0, 1'b1, 3'd5, 3'd0, 1'b0);
      access(32'h0500_0000, 3'd5, 1'b1);  check("R6 both match", 1'b1, 1'b1);
      access(32'h0500_0000, 3'd5, 1'b0);  check("R6 only no-ci window", 1'b1, 1'b0);

      // R4: code mask don't-care bit 2 on window 1 (base 1, mask 4 -> codes 1 and 5)
      write_win(1'b1, 1'b1, 8'h00, 8'h0F, 1'b0, 1'b1, 3'd1, 3'd4, 1'b0);
      access(32'h0500_0000, 3'd1, 1'b0);  check("R4 masked code 1", 1'b1, 1'b0);
      access(32'h0500_0000, 3'd3, 1'b0);  check("R4 code 3 outside", 1'b0, 1'b0);

      // R3: write-only window matches writes, not reads
      write_win(1'b1, 1'b1, 8'hA0, 8'h00, 1'b0, 1'b0, 3'd6, 3'd1, 1'b1);
      access(32'hA012_3456, 3'd7, 1'b0);  check("R3 write window write", 1'b1, 1'b1);
      access(32'hA012_3456, 3'd7, 1'b1);  check("R3 write window read", 1'b0, 1'b0);

      // R9: disabling write in the same cycle as a hitting access
      access(32'h0123_0000, 3'd5, 1'b1);
      wr_en = 1'b1; wr_sel = 1'b0; wr_on = 1'b0; wr_ci = 1'b0;
      #1;  check("R9 old config before edge", 1'b1, 1'b1);
      @(negedge clk); wr_en = 1'b0; #1;
      // R5: disabled window no longer matches the same access
      check("R5/R9 disabled after edge", 1'b0, 1'b0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout, want completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule